// File: doc/BRIEF.md
# Processor Idle-State Entry and Wake Sequencer

This block sits in a system I/O hub and controls the processor's light (C2) and deep (C3) idle states. After an idle request it waits for the host to broadcast Stop Grant. A light entry finishes there and drives no pins. A deep entry can pull three active-low pins low, each only if it is enabled: a graphics-halt pin, a processor-sleep pin and, after a programmable delay, a link-halt pin.

When a wake event arrives, the block releases the pins it pulled low, in a fixed order. The delays between releases depend on which pins were in use: a fixed gap of 250 microsecond ticks follows the release of the sleep pin, and a programmable graphics delay follows the release of the link-halt pin. When every pin is high again, it raises a one-cycle strobe that asks the link layer to send a clock-stop-released message to the host, and it returns to idle. All delays count a one-cycle microsecond tick. Enables and delay counts are captured when the request is accepted.

Top module: `cstate_seq`

## Requirements
- R1: After reset, all three pins are high and `msg_req` is low.
- R2: After a request, no pin moves and `msg_req` stays low until Stop Grant arrives. For a light request (`req_deep`=0), Stop Grant finishes entry with all pins still high.
- R3: For a deep request, the cycle after Stop Grant `gfx_halt_n` is low if `cfg_halt_gfx` was 1, and `proc_sleep_n` is low if `cfg_sleep` was 1.
- R4: `link_halt_n` goes low once `link_dly` ticks have been counted from Stop Grant, and only when `cfg_halt_link` is 1.
- R5: A wake during a light idle state raises `msg_req` in the next cycle.
- R6: On a deep wake with the sleep pin low, `proc_sleep_n` rises the next cycle and 250 ticks then pass before any other pin moves.
- R7: When the link-halt pin is in use, it is released (after the R6 gap, if that applies), and then `gfx_dly` ticks pass before `gfx_halt_n` rises.
- R8: With the sleep pin used and the link-halt pin not used, `gfx_halt_n` rises once the 250-tick gap ends.
- R9: With neither the sleep pin nor the link-halt pin used, `gfx_halt_n` rises `gfx_dly` ticks after the wake.
- R10: `msg_req` is a single-cycle pulse. It is issued only after all pins are high, and the block then accepts a new request.
- R11: A pin whose enable was 0 at request time stays high for the whole entry and wake.
- R12: A wake before Stop Grant cancels the request and raises `msg_req` in the next cycle.
- R13: Changes to the enables or delays after a request is accepted have no effect on that entry. A request made while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Idle-state request pulse, accepted only when idle |
| req_deep | input | 1 | 1 = deep (C3) entry, 0 = light (C2) entry |
| stop_grant | input | 1 | Stop Grant broadcast seen from host (pulse) |
| wake | input | 1 | Enabled resume event (pulse) |
| cfg_halt_gfx | input | 1 | Enable graphics-halt pin in deep state |
| cfg_sleep | input | 1 | Enable processor-sleep pin in deep state |
| cfg_halt_link | input | 1 | Enable link-halt pin in deep state |
| link_dly | input | 8 | Ticks from Stop Grant to link-halt assertion |
| gfx_dly | input | 8 | Ticks before graphics-halt release |
| us_tick | input | 1 | One-cycle microsecond tick |
| gfx_halt_n | output | 1 | Graphics-halt pin, active low |
| proc_sleep_n | output | 1 | Processor-sleep pin, active low |
| link_halt_n | output | 1 | Link-halt pin, active low |
| msg_req | output | 1 | One-cycle request for a clock-stop-released message |

## Verification
The assertions assume that `stop_grant` and `wake` are single-cycle pulses, that `req_valid` matters only while idle, and that the microsecond tick is at most one cycle wide. The stimulus drives every event as a one-cycle pulse on the falling edge and produces the tick from a divider. It also pulses a request in the middle of a busy sequence and changes the configuration after a request is accepted, so that the cases the block must ignore are seen at the pins. A behavioural model in the bench predicts every pin and the strobe on each clock, across all the enable combinations, a zero link delay, a wake before Stop Grant and a wake while the link delay is still running.

// File: rtl/cseq_pkg.sv
// Package: shared state encoding and pin indices for the idle-state sequencer.
// Assumes: pin indices are used consistently by the pin bank and the FSM.
package cseq_pkg;
    localparam int NUM_PINS = 3;
    localparam int PIN_GFX  = 0;
    localparam int PIN_SLP  = 1;
    localparam int PIN_LNK  = 2;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WAIT_SG   = 3'd1,
        ST_LIGHT     = 3'd2,
        ST_LINK_WAIT = 3'd3,
        ST_DEEP      = 3'd4,
        ST_SLP_GAP   = 3'd5,
        ST_GFX_WAIT  = 3'd6,
        ST_MSG       = 3'd7
    } cseq_state_e;
endpackage

// File: rtl/cseq_timer.sv
// Module: tick-driven down counter. A load sets the count; each tick lowers
// it by one until it reaches zero, and done is high while the count is zero.
// Assumes: load has priority over a tick in the same cycle.
module cseq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Counter register: load, otherwise count down on a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && (cnt != '0))
            cnt <= cnt - 1'b1;
    end

    // Done flag: the delay has run out.
    assign done = (cnt == '0);

    // R6: the count never rises unless it is loaded.
    a_r6_no_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (cnt <= $past(cnt)));
    // R7: a load takes effect on the next cycle.
    a_r7_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/cseq_pins.sv
// Module: bank of active-low pin flops with per-pin set and clear strobes.
// Assumes: set and clear for the same pin are never raised together.
module cseq_pins #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] held,
    output logic [N-1:0] pin_n
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        // Per-pin hold flop: clear wins, then set.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held[i] <= 1'b0;
            else if (clr[i])
                held[i] <= 1'b0;
            else if (set[i])
                held[i] <= 1'b1;
        end

        // R1: the controller never drives set and clear together.
        a_r1_set_clr_excl: assert property (@(posedge clk) disable iff (!rst_n)
            !(set[i] && clr[i]));
    end

    // Active-low pin outputs.
    assign pin_n = ~held;
endmodule

// File: rtl/cseq_fsm.sv
// Module: sequencing FSM for idle-state entry and wake. It captures the
// configuration at request time, waits for Stop Grant, orders pin assertion
// and release, and raises the message strobe.
// Assumes: stop_grant and wake are single-cycle pulses.
module cseq_fsm
    import cseq_pkg::*;
#(
    parameter int DLY_W     = 8,
    parameter int CW        = 8,
    parameter int GAP_TICKS = 250
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_deep,
    input  logic                stop_grant,
    input  logic                wake,
    input  logic [NUM_PINS-1:0] en,
    input  logic [DLY_W-1:0]    link_dly,
    input  logic [DLY_W-1:0]    gfx_dly,
    input  logic [NUM_PINS-1:0] held,
    input  logic                tmr_done,
    output logic [NUM_PINS-1:0] pin_set,
    output logic [NUM_PINS-1:0] pin_clr,
    output logic                tmr_load,
    output logic [CW-1:0]       tmr_val,
    output logic                msg_req
);
    cseq_state_e st, st_nx;
    logic                deep_q;
    logic [NUM_PINS-1:0] en_q;
    logic [DLY_W-1:0]    ldly_q, gdly_q;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Capture the configuration when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deep_q <= 1'b0;
            en_q   <= '0;
            ldly_q <= '0;
            gdly_q <= '0;
        end else if (st == ST_IDLE && req_valid) begin
            deep_q <= req_deep;
            en_q   <= en;
            ldly_q <= link_dly;
            gdly_q <= gfx_dly;
        end
    end

    // Next state, pin strobes and timer loads.
    always_comb begin
        st_nx    = st;
        pin_set  = '0;
        pin_clr  = '0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st)
            ST_IDLE:
                if (req_valid) st_nx = ST_WAIT_SG;
            ST_WAIT_SG:
                if (wake)
                    st_nx = ST_MSG;
                else if (stop_grant) begin
                    if (deep_q) begin
                        pin_set[PIN_GFX] = en_q[PIN_GFX];
                        pin_set[PIN_SLP] = en_q[PIN_SLP];
                        tmr_load = 1'b1;
                        tmr_val  = CW'(ldly_q);
                        st_nx    = ST_LINK_WAIT;
                    end else
                        st_nx = ST_LIGHT;
                end
            ST_LIGHT:
                if (wake) st_nx = ST_MSG;
            ST_LINK_WAIT, ST_DEEP:
                if (wake) begin
                    tmr_load = 1'b1;
                    if (held[PIN_SLP]) begin
                        pin_clr[PIN_SLP] = 1'b1;
                        tmr_val = CW'(GAP_TICKS);
                        st_nx   = ST_SLP_GAP;
                    end else begin
                        pin_clr[PIN_LNK] = 1'b1;
                        tmr_val = CW'(gdly_q);
                        st_nx   = ST_GFX_WAIT;
                    end
                end else if (st == ST_LINK_WAIT && tmr_done) begin
                    pin_set[PIN_LNK] = en_q[PIN_LNK];
                    st_nx = ST_DEEP;
                end
            ST_SLP_GAP:
                if (tmr_done) begin
                    if (held[PIN_LNK]) begin
                        pin_clr[PIN_LNK] = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(gdly_q);
                        st_nx    = ST_GFX_WAIT;
                    end else begin
                        pin_clr[PIN_GFX] = 1'b1;
                        st_nx = ST_MSG;
                    end
                end
            ST_GFX_WAIT:
                if (tmr_done) begin
                    pin_clr[PIN_GFX] = 1'b1;
                    st_nx = ST_MSG;
                end
            ST_MSG:
                st_nx = ST_IDLE;
            default:
                st_nx = ST_IDLE;
        endcase
    end

    // Message strobe: high for the one cycle spent in the message state.
    assign msg_req = (st == ST_MSG);

    // R11: a pin is held only if its enable was captured as 1.
    a_r11_held_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        ((held & ~en_q) == '0));
    // R2: a light idle state holds no pin.
    a_r2_light_no_pins: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LIGHT) |-> (held == '0));
    // R6: the sleep pin is already released during the fixed gap.
    a_r6_sleep_first: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLP_GAP) |-> !held[PIN_SLP]);
    // R10: the strobe lasts one cycle.
    a_r10_msg_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |=> !msg_req);
    // R10: the strobe comes only once every pin is high again.
    a_r10_msg_all_high: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req |-> (held == '0));
endmodule

// File: rtl/cstate_seq.sv
// Module: top of the processor idle-state entry and wake sequencer. It joins
// the FSM, the shared delay timer and the pin bank.
// Assumes: us_tick is at most one cycle wide and GAP_TICKS fits the timer.
module cstate_seq
    import cseq_pkg::*;
#(
    parameter int DLY_W     = 8,
    parameter int GAP_TICKS = 250
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_deep,
    input  logic             stop_grant,
    input  logic             wake,
    input  logic             cfg_halt_gfx,
    input  logic             cfg_sleep,
    input  logic             cfg_halt_link,
    input  logic [DLY_W-1:0] link_dly,
    input  logic [DLY_W-1:0] gfx_dly,
    input  logic             us_tick,
    output logic             gfx_halt_n,
    output logic             proc_sleep_n,
    output logic             link_halt_n,
    output logic             msg_req
);
    localparam int GAP_W = $clog2(GAP_TICKS + 1);
    localparam int CW    = (DLY_W > GAP_W) ? DLY_W : GAP_W;

    logic [NUM_PINS-1:0] en, held, pin_set, pin_clr, pin_n;
    logic                tmr_load, tmr_done;
    logic [CW-1:0]       tmr_val;

    // Gather the enables into pin order.
    always_comb begin
        en          = '0;
        en[PIN_GFX] = cfg_halt_gfx;
        en[PIN_SLP] = cfg_sleep;
        en[PIN_LNK] = cfg_halt_link;
    end

    cseq_fsm #(.DLY_W(DLY_W), .CW(CW), .GAP_TICKS(GAP_TICKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_deep(req_deep),
        .stop_grant(stop_grant), .wake(wake), .en(en), .link_dly(link_dly),
        .gfx_dly(gfx_dly), .held(held), .tmr_done(tmr_done),
        .pin_set(pin_set), .pin_clr(pin_clr), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .msg_req(msg_req)
    );

    cseq_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .tick(us_tick), .done(tmr_done)
    );

    cseq_pins #(.N(NUM_PINS)) u_pins (
        .clk(clk), .rst_n(rst_n), .set(pin_set), .clr(pin_clr),
        .held(held), .pin_n(pin_n)
    );

    assign gfx_halt_n   = pin_n[PIN_GFX];
    assign proc_sleep_n = pin_n[PIN_SLP];
    assign link_halt_n  = pin_n[PIN_LNK];
endmodule

// File: tb/cstate_seq_tb_top.sv
// Bench: a behavioural reference model predicts every output on each clock;
// directed checks cover reset, ignored inputs and the ordering corner cases.
module cstate_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int GAP = 250;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, req_deep = 0, stop_grant = 0, wake = 0;
    logic cfg_halt_gfx = 0, cfg_sleep = 0, cfg_halt_link = 0;
    logic [7:0] link_dly = 0, gfx_dly = 0;
    logic us_tick = 0;
    logic gfx_halt_n, proc_sleep_n, link_halt_n, msg_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tdiv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cstate_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_deep(req_deep),
        .stop_grant(stop_grant), .wake(wake), .cfg_halt_gfx(cfg_halt_gfx),
        .cfg_sleep(cfg_sleep), .cfg_halt_link(cfg_halt_link),
        .link_dly(link_dly), .gfx_dly(gfx_dly), .us_tick(us_tick),
        .gfx_halt_n(gfx_halt_n), .proc_sleep_n(proc_sleep_n),
        .link_halt_n(link_halt_n), .msg_req(msg_req)
    );

    // Microsecond tick: one cycle in every three.
    always @(negedge clk) begin
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        us_tick = (tdiv == 0);
    end

    // Reference model, phases: 0 idle, 1 wait Stop Grant, 2 light, 3 link wait,
    // 4 deep, 5 sleep gap, 6 graphics wait, 7 message.
    int  m_ph = 0, m_cnt = 0, m_ld = 0, m_gd = 0;
    bit  m_deep = 0, m_eg = 0, m_es = 0, m_el = 0;
    bit  m_g = 0, m_s = 0, m_l = 0;

    task automatic m_resume();
        if (m_s) begin
            m_s = 0; m_cnt = GAP; m_ph = 5;
        end else begin
            m_l = 0; m_cnt = m_gd; m_ph = 6;
        end
    endtask

    always @(posedge clk) begin
        bit done;
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_g = 0; m_s = 0; m_l = 0;
            m_deep = 0; m_eg = 0; m_es = 0; m_el = 0; m_ld = 0; m_gd = 0;
        end else begin
            done = (m_cnt == 0);
            if (us_tick && m_cnt > 0) m_cnt = m_cnt - 1;
            case (m_ph)
                0: if (req_valid) begin
                       m_deep = req_deep; m_eg = cfg_halt_gfx; m_es = cfg_sleep;
                       m_el = cfg_halt_link; m_ld = link_dly; m_gd = gfx_dly;
                       m_ph = 1;
                   end
                1: if (wake) m_ph = 7;
                   else if (stop_grant) begin
                       if (m_deep) begin
                           m_g = m_eg; m_s = m_es; m_cnt = m_ld; m_ph = 3;
                       end else m_ph = 2;
                   end
                2: if (wake) m_ph = 7;
                3: if (wake) m_resume();
                   else if (done) begin m_l = m_el; m_ph = 4; end
                4: if (wake) m_resume();
                5: if (done) begin
                       if (m_l) begin m_l = 0; m_cnt = m_gd; m_ph = 6; end
                       else begin m_g = 0; m_ph = 7; end
                   end
                6: if (done) begin m_g = 0; m_ph = 7; end
                default: m_ph = 0;
            endcase
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        cycles++;
        checks++;
        if (gfx_halt_n !== !m_g) begin
            errors++;
            $display("FAIL R3 R7 R8 R9 gfx_halt_n actual=%0d expected=%0d", gfx_halt_n, !m_g);
        end
        if (proc_sleep_n !== !m_s) begin
            errors++;
            $display("FAIL R3 R6 proc_sleep_n actual=%0d expected=%0d", proc_sleep_n, !m_s);
        end
        if (link_halt_n !== !m_l) begin
            errors++;
            $display("FAIL R4 R7 link_halt_n actual=%0d expected=%0d", link_halt_n, !m_l);
        end
        if (msg_req !== (m_ph == 7)) begin
            errors++;
            $display("FAIL R5 R10 R12 msg_req actual=%0d expected=%0d", msg_req, m_ph == 7);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic wait_phase(input int ph);
        for (int i = 0; i < 4000 && m_ph != ph; i++) @(negedge clk);
    endtask

    task automatic set_cfg(input bit g, input bit s, input bit l, input int ld, input int gd);
        @(negedge clk);
        cfg_halt_gfx = g; cfg_sleep = s; cfg_halt_link = l;
        link_dly = 8'(ld); gfx_dly = 8'(gd);
    endtask

    task automatic deep_run(input bit g, input bit s, input bit l,
                            input int ld, input int gd, input bit early);
        set_cfg(g, s, l, ld, gd);
        req_deep = 1'b1;
        pulse(req_valid);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(gfx_halt_n && proc_sleep_n && link_halt_n && !msg_req,
                "R2 pins idle before Stop Grant", {gfx_halt_n, proc_sleep_n, link_halt_n}, 7);
        end
        pulse(stop_grant);
        chk(gfx_halt_n == !g, "R3 gfx after Stop Grant", gfx_halt_n, !g);
        chk(proc_sleep_n == !s, "R3 sleep after Stop Grant", proc_sleep_n, !s);
        if (early) begin
            repeat (2) @(negedge clk);
        end else begin
            wait_phase(4);
            repeat (4) @(negedge clk);
            if (!l) chk(link_halt_n == 1'b1, "R11 disabled link pin", link_halt_n, 1);
            if (!s) chk(proc_sleep_n == 1'b1, "R11 disabled sleep pin", proc_sleep_n, 1);
            pulse(req_valid);
            chk(m_ph == 4, "R13 request while busy ignored", m_ph, 4);
        end
        pulse(wake);
        wait_phase(0);
        chk(gfx_halt_n && proc_sleep_n && link_halt_n, "R10 all released at end",
            {gfx_halt_n, proc_sleep_n, link_halt_n}, 7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(gfx_halt_n && proc_sleep_n && link_halt_n, "R1 pins after reset",
            {gfx_halt_n, proc_sleep_n, link_halt_n}, 7);
        chk(!msg_req, "R1 msg_req after reset", msg_req, 0);
        rst_n = 1'b1;

        // Light entry.
        set_cfg(1, 1, 1, 2, 2);
        req_deep = 1'b0;
        pulse(req_valid);
        pulse(stop_grant);
        repeat (3) @(negedge clk);
        chk(gfx_halt_n && proc_sleep_n && link_halt_n, "R2 light state drives no pin",
            {gfx_halt_n, proc_sleep_n, link_halt_n}, 7);
        pulse(wake);
        chk(msg_req == 1'b1, "R5 message after light wake", msg_req, 1);
        @(negedge clk);
        chk(msg_req == 1'b0, "R10 message is one cycle", msg_req, 0);

        deep_run(1, 1, 1, 5, 7, 0);   // R6 R7 full sequence
        deep_run(1, 1, 0, 3, 9, 0);   // R8 sleep without link
        deep_run(1, 0, 0, 0, 3, 0);   // R9 neither sleep nor link
        deep_run(0, 0, 1, 0, 0, 0);   // R7 link only, zero delays
        deep_run(1, 0, 1, 4, 2, 0);   // R7 link without sleep
        deep_run(1, 1, 1, 200, 5, 1); // wake during link delay

        // Wake before Stop Grant cancels the request.
        set_cfg(1, 1, 1, 1, 1);
        req_deep = 1'b1;
        pulse(req_valid);
        pulse(wake);
        chk(msg_req == 1'b1, "R12 cancel raises message", msg_req, 1);
        wait_phase(0);

        // Configuration changes after acceptance are ignored.
        set_cfg(1, 0, 0, 1, 4);
        req_deep = 1'b1;
        pulse(req_valid);
        set_cfg(0, 1, 1, 1, 4);
        pulse(stop_grant);
        chk(gfx_halt_n == 1'b0, "R13 captured gfx enable kept", gfx_halt_n, 0);
        chk(proc_sleep_n == 1'b1, "R13 late sleep enable ignored", proc_sleep_n, 1);
        wait_phase(4);
        @(negedge clk);
        chk(link_halt_n == 1'b1, "R13 late link enable ignored", link_halt_n, 1);
        pulse(wake);
        wait_phase(0);
        repeat (3) @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule